// File: doc/BRIEF.md
# Reset Sequencer with Write Lockout

This block brings a memory-bearing peripheral out of reset. It tells a cold start apart from a reset taken while the part is already running. A cold start begins when the supply-good flag rises. The block then issues a single configuration-load strobe. It waits for a qualifying low pulse on the reset pin and for the configuration-done handshake. After that it holds off memory access for a fixed recovery time measured from the reset pin's rising edge. A later low pulse on the reset pin while running is a warm reset. It needs only a shorter minimum width and reuses the same recovery time. Pulses shorter than the applicable minimum are treated as glitches and leave the sequence untouched.

Beside the ready flag, the block produces several other outputs. One forces the memories into read mode until the first power-on sequence completes. Another reports when logic-array outputs may be trusted. A third blocks write strobes to the electrically erasable array for a long window after power-up; that window runs on its own counter and can outlast recovery. A flash-write inhibit follows the low-voltage lockout flag and the ready state.

All durations are parameters in clock cycles. The default write-block window is derived from a clock-frequency parameter as 5 ms. Dropping the supply-good flag resets everything at once, without waiting for a clock edge.

Top module: `rsq_top`

## Requirements
- R1: While `supply_good` is low, and immediately when it falls, the outputs are: `ready`=0, `cfg_load`=0, `force_read`=1, `logic_valid`=0, `ee_wr_block`=1, `flash_wr_inhibit`=1.
- R2: On the first clock edge after `supply_good` rises, `cfg_load` goes high for exactly one cycle and is not repeated until the next power-up.
- R3: The power-on sequence is qualified only after `reset_in_n` is sampled low on POR_CYC consecutive clock edges. A shorter low run is ignored, and the count restarts at the next low sample.
- R4: Recovery does not begin until `cfg_done` has been seen high on some edge after power-up. `cfg_done` may arrive during the pulse or after it.
- R5: `ready` rises after `reset_in_n` has been sampled high on REC_CYC consecutive edges in recovery. Any low sample during recovery restarts the count.
- R6: `ready` is registered. It is high only in the running state or while an unqualified warm pulse is being measured.
- R7: While running, a low run of `reset_in_n` shorter than WARM_CYC edges leaves `ready` high. Reaching WARM_CYC low edges drops `ready` on that edge and enters recovery.
- R8: `logic_valid` rises with the first `cfg_done` after power-up and stays high through warm resets until the supply drops.
- R9: `force_read` stays high from power-up until `ready` first rises, then stays low until the supply drops.
- R10: `ee_wr_block` is high for the first WBLK_CYC clock edges after `supply_good` rises, regardless of the sequencer state, then stays low until the supply drops.
- R11: `flash_wr_inhibit` is high whenever `below_lockout` is high or `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_good | input | 1 | Supply steady flag, asynchronous active-low reset of the whole block |
| reset_in_n | input | 1 | Active-low reset pin, sampled on clk |
| below_lockout | input | 1 | Supply is below the flash write lockout threshold |
| cfg_done | input | 1 | Configuration loading has completed |
| cfg_load | output | 1 | One-cycle configuration load strobe |
| ready | output | 1 | Memory access allowed |
| force_read | output | 1 | Hold memories in read mode |
| logic_valid | output | 1 | Logic-array outputs may be trusted |
| ee_wr_block | output | 1 | Suppress write strobes to the erasable array |
| flash_wr_inhibit | output | 1 | Suppress the start of flash write cycles |

## Verification
The bench builds the block with a power-on width of 20, a warm width of 6, a recovery of 10 and a write-block window of 400 cycles. This makes every boundary reachable in a few hundred cycles. It drives pulses of exactly the minimum width and one cycle short of it, and interrupts recovery with a short low run. Because the window is longer than a full power-on sequence, the bench can show the write block still active after `ready` rises, then expiring later. A second power-up with a late `cfg_done` exercises the wait for configuration and the restart of the window.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,   // supply just became good
        ST_POR  = 3'd1,   // measuring the power-on pulse
        ST_CFG  = 3'd2,   // pulse qualified, waiting for configuration
        ST_REC  = 3'd3,   // recovery delay after the pin rises
        ST_RUN  = 3'd4,   // operational
        ST_WARM = 3'd5    // measuring a low pulse while running
    } seq_state_e;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rsq_ctrl.sv
`timescale 1ns/1ps
module rsq_ctrl
    import rsq_pkg::*;
#(
    parameter int unsigned POR_CYC  = 64,
    parameter int unsigned WARM_CYC = 8,
    parameter int unsigned REC_CYC  = 32
) (
    input  logic clk,
    input  logic supply_good,
    input  logic reset_in_n,
    input  logic cfg_done,
    output logic cfg_load,
    output logic ready,
    output logic force_read,
    output logic logic_valid
);

    localparam int unsigned CMAX = max3(POR_CYC, WARM_CYC, REC_CYC);
    localparam int unsigned CW   = $clog2(CMAX + 1);
    localparam logic [CW:0] POR_LIM  = (CW+1)'(POR_CYC);
    localparam logic [CW:0] WARM_LIM = (CW+1)'(WARM_CYC);
    localparam logic [CW:0] REC_LIM  = (CW+1)'(REC_CYC);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          seen;   // configuration done since power-up
        logic          pdone;  // first power-on sequence finished
        logic          rdy;
        logic          cfg;
    } ctrl_regs_t;

    localparam ctrl_regs_t RST = '{st: ST_OFF, cnt: '0, seen: 1'b0,
                                   pdone: 1'b0, rdy: 1'b0, cfg: 1'b0};

    ctrl_regs_t  r_q, r_d;
    logic [CW:0] inc;

    assign inc = {1'b0, r_q.cnt} + 1'b1;

    always_comb begin
        r_d     = r_q;
        r_d.cfg = 1'b0;
        if (r_q.st != ST_OFF && cfg_done) begin
            r_d.seen = 1'b1;
        end
        case (r_q.st)
            ST_OFF: begin
                r_d.st  = ST_POR;
                r_d.cnt = '0;
                r_d.cfg = 1'b1;
            end
            ST_POR: begin
                if (!reset_in_n) begin
                    if (inc >= POR_LIM) begin
                        r_d.st  = ST_CFG;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = inc[CW-1:0];
                    end
                end else begin
                    r_d.cnt = '0;
                end
            end
            ST_CFG: begin
                if (r_d.seen) begin
                    r_d.st  = ST_REC;
                    r_d.cnt = '0;
                end
            end
            ST_REC: begin
                if (!reset_in_n) begin
                    r_d.cnt = '0;
                end else if (inc >= REC_LIM) begin
                    r_d.st  = ST_RUN;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = inc[CW-1:0];
                end
            end
            ST_RUN, ST_WARM: begin
                if (!reset_in_n) begin
                    if (inc >= WARM_LIM) begin
                        r_d.st  = ST_REC;
                        r_d.cnt = '0;
                    end else begin
                        r_d.st  = ST_WARM;
                        r_d.cnt = inc[CW-1:0];
                    end
                end else begin
                    r_d.st  = ST_RUN;
                    r_d.cnt = '0;
                end
            end
            default: r_d = RST;
        endcase
        r_d.rdy = (r_d.st == ST_RUN) || (r_d.st == ST_WARM);
        if (r_d.st == ST_RUN) begin
            r_d.pdone = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge supply_good) begin
        if (!supply_good) begin
            r_q <= RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_load    = r_q.cfg;
    assign ready       = r_q.rdy;
    assign force_read  = !r_q.pdone;
    assign logic_valid = r_q.seen;

    p_cfg_single_r2: assert property (@(posedge clk) disable iff (!supply_good)
        r_q.cfg |=> !r_q.cfg);

    p_por_qualified_r3: assert property (@(posedge clk) disable iff (!supply_good)
        (r_q.st == ST_CFG && $past(r_q.st) == ST_POR) |-> !$past(reset_in_n));

    p_rec_needs_cfg_r4: assert property (@(posedge clk) disable iff (!supply_good)
        (r_q.st == ST_REC) |-> r_q.seen);

    p_ready_from_rec_r5: assert property (@(posedge clk) disable iff (!supply_good)
        $rose(r_q.rdy) |-> ($past(r_q.st) == ST_REC && $past(reset_in_n)));

    p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!supply_good)
        r_q.seen |=> r_q.seen);

    p_ready_clears_read_r9: assert property (@(posedge clk) disable iff (!supply_good)
        r_q.rdy |-> !force_read);

endmodule

// File: rtl/rsq_wr_guard.sv
`timescale 1ns/1ps
module rsq_wr_guard #(
    parameter int unsigned WBLK_CYC = 1250000
) (
    input  logic clk,
    input  logic supply_good,
    input  logic below_lockout,
    input  logic ready,
    output logic ee_wr_block,
    output logic flash_wr_inhibit
);

    localparam int unsigned WW = (WBLK_CYC < 1) ? 1 : $clog2(WBLK_CYC + 1);
    localparam logic [WW-1:0] WLIM = WW'(WBLK_CYC);

    generate
        if (WBLK_CYC == 0) begin : g_no_window
            assign ee_wr_block = 1'b0;
        end else begin : g_window
            logic [WW-1:0] cnt_q, cnt_d;

            always_comb begin
                cnt_d = cnt_q;
                if (cnt_q < WLIM) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge supply_good) begin
                if (!supply_good) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign ee_wr_block = (cnt_q < WLIM);
        end
    endgenerate

    assign flash_wr_inhibit = below_lockout || !ready;

    p_window_once_r10: assert property (@(posedge clk) disable iff (!supply_good)
        !ee_wr_block |=> !ee_wr_block);

    p_ready_not_locked_r11: assert property (@(posedge clk) disable iff (!supply_good)
        (ready && !below_lockout) |-> !flash_wr_inhibit);

endmodule

// File: rtl/rsq_top.sv
`timescale 1ns/1ps
module rsq_top #(
    parameter int unsigned CLK_HZ   = 250000000,
    parameter int unsigned POR_CYC  = 64,
    parameter int unsigned WARM_CYC = 8,
    parameter int unsigned REC_CYC  = 32,
    parameter int unsigned WBLK_CYC = CLK_HZ / 200
) (
    input  logic clk,
    input  logic supply_good,
    input  logic reset_in_n,
    input  logic below_lockout,
    input  logic cfg_done,
    output logic cfg_load,
    output logic ready,
    output logic force_read,
    output logic logic_valid,
    output logic ee_wr_block,
    output logic flash_wr_inhibit
);

    logic rdy;

    rsq_ctrl #(
        .POR_CYC  (POR_CYC),
        .WARM_CYC (WARM_CYC),
        .REC_CYC  (REC_CYC)
    ) i_ctrl (
        .clk         (clk),
        .supply_good (supply_good),
        .reset_in_n  (reset_in_n),
        .cfg_done    (cfg_done),
        .cfg_load    (cfg_load),
        .ready       (rdy),
        .force_read  (force_read),
        .logic_valid (logic_valid)
    );

    rsq_wr_guard #(
        .WBLK_CYC (WBLK_CYC)
    ) i_guard (
        .clk              (clk),
        .supply_good      (supply_good),
        .below_lockout    (below_lockout),
        .ready            (rdy),
        .ee_wr_block      (ee_wr_block),
        .flash_wr_inhibit (flash_wr_inhibit)
    );

    assign ready = rdy;

endmodule

// File: tb/test_rsq_top.sv
`timescale 1ns/1ps
module test_rsq_top;

    localparam int POR  = 20;
    localparam int WARM = 6;
    localparam int REC  = 10;
    localparam int WBLK = 400;

    logic clk = 1'b0;
    logic supply_good = 1'b0;
    logic reset_in_n = 1'b1;
    logic below_lockout = 1'b0;
    logic cfg_done = 1'b0;
    logic cfg_load, ready, force_read, logic_valid, ee_wr_block, flash_wr_inhibit;

    int n_checks = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    rsq_top #(
        .CLK_HZ   (250000000),
        .POR_CYC  (POR),
        .WARM_CYC (WARM),
        .REC_CYC  (REC),
        .WBLK_CYC (WBLK)
    ) i_rsq_top (
        .clk              (clk),
        .supply_good      (supply_good),
        .reset_in_n       (reset_in_n),
        .below_lockout    (below_lockout),
        .cfg_done         (cfg_done),
        .cfg_load         (cfg_load),
        .ready            (ready),
        .force_read       (force_read),
        .logic_valid      (logic_valid),
        .ee_wr_block      (ee_wr_block),
        .flash_wr_inhibit (flash_wr_inhibit)
    );

    // Behavioural reference: phase 0 off, 1 power-on pulse, 2 config wait,
    // 3 recovery, 4 running, 5 warm pulse being measured.
    int phase = 0;
    int run_len = 0;
    int elapsed = 0;
    bit seen = 1'b0;
    bit booted = 1'b0;
    bit m_rdy = 1'b0;
    bit m_cfg = 1'b0;

    always @(posedge clk or negedge supply_good) begin
        if (!supply_good) begin
            phase = 0; run_len = 0; elapsed = 0;
            seen = 1'b0; booted = 1'b0; m_rdy = 1'b0; m_cfg = 1'b0;
        end else begin
            m_cfg = (phase == 0);
            if (phase != 0 && cfg_done) seen = 1'b1;
            if (elapsed < WBLK) elapsed++;
            if (phase == 0) begin
                phase = 1; run_len = 0;
            end else if (phase == 1) begin
                if (!reset_in_n) begin
                    run_len++;
                    if (run_len >= POR) begin phase = 2; run_len = 0; end
                end else run_len = 0;
            end else if (phase == 2) begin
                if (seen) begin phase = 3; run_len = 0; end
            end else if (phase == 3) begin
                if (!reset_in_n) run_len = 0;
                else begin
                    run_len++;
                    if (run_len >= REC) begin phase = 4; run_len = 0; end
                end
            end else begin
                if (!reset_in_n) begin
                    run_len++;
                    if (run_len >= WARM) begin phase = 3; run_len = 0; end
                    else phase = 5;
                end else begin
                    phase = 4; run_len = 0;
                end
            end
            if (phase == 4) booted = 1'b1;
            m_rdy = (phase == 4) || (phase == 5);
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        chk("R6 ready", ready, m_rdy);
        chk("R2 cfg_load", cfg_load, m_cfg);
        chk("R9 force_read", force_read, !booted);
        chk("R8 logic_valid", logic_valid, seen);
        chk("R10 ee_wr_block", ee_wr_block, elapsed < WBLK);
        chk("R11 flash_wr_inhibit", flash_wr_inhibit, below_lockout || !m_rdy);
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check_off(string tag);
        chk(tag, ready, 1'b0);
        chk(tag, cfg_load, 1'b0);
        chk(tag, force_read, 1'b1);
        chk(tag, logic_valid, 1'b0);
        chk(tag, ee_wr_block, 1'b1);
        chk(tag, flash_wr_inhibit, 1'b1);
    endtask

    initial begin
        step(3);
        check_off("R1 supply low");

        supply_good = 1'b1;
        step(1);
        chk("R2 strobe high", cfg_load, 1'b1);
        step(1);
        chk("R2 strobe one cycle", cfg_load, 1'b0);
        cfg_done = 1'b1;
        step(1);
        cfg_done = 1'b0;
        chk("R8 valid after done", logic_valid, 1'b1);

        // one cycle short of the power-on width
        reset_in_n = 1'b0;
        step(POR - 1);
        reset_in_n = 1'b1;
        step(30);
        chk("R3 short por pulse ignored", ready, 1'b0);

        // exactly the power-on width
        reset_in_n = 1'b0;
        step(POR);
        reset_in_n = 1'b1;
        step(REC);
        chk("R5 still recovering", ready, 1'b0);
        step(1);
        chk("R5 ready after recovery", ready, 1'b1);
        chk("R9 read mode released", force_read, 1'b0);
        chk("R10 window outlasts recovery", ee_wr_block, 1'b1);

        // warm glitch one cycle short
        reset_in_n = 1'b0;
        step(WARM - 1);
        chk("R7 ready held during glitch", ready, 1'b1);
        reset_in_n = 1'b1;
        step(3);
        chk("R7 glitch ignored", ready, 1'b1);

        // qualified warm reset with interrupted recovery
        reset_in_n = 1'b0;
        step(WARM);
        chk("R7 warm reset drops ready", ready, 1'b0);
        chk("R8 valid held in warm reset", logic_valid, 1'b1);
        step(4);
        reset_in_n = 1'b1;
        step(4);
        reset_in_n = 1'b0;
        step(2);
        reset_in_n = 1'b1;
        step(REC - 1);
        chk("R5 recovery restarted", ready, 1'b0);
        step(1);
        chk("R5 ready after warm recovery", ready, 1'b1);

        below_lockout = 1'b1;
        step(1);
        chk("R11 lockout inhibits flash", flash_wr_inhibit, 1'b1);
        below_lockout = 1'b0;
        step(1);
        chk("R11 inhibit released", flash_wr_inhibit, 1'b0);

        step(WBLK);
        chk("R10 window expired", ee_wr_block, 1'b0);

        // supply drop acts at once
        supply_good = 1'b0;
        #0.5;
        check_off("R1 async drop");
        step(2);

        // second power-up with late configuration
        supply_good = 1'b1;
        step(1);
        chk("R10 window restarted", ee_wr_block, 1'b1);
        reset_in_n = 1'b0;
        step(POR);
        reset_in_n = 1'b1;
        step(REC + 5);
        chk("R4 waits for configuration", ready, 1'b0);
        chk("R8 not valid before done", logic_valid, 1'b0);
        chk("R9 read mode held", force_read, 1'b1);
        cfg_done = 1'b1;
        step(1);
        cfg_done = 1'b0;
        step(REC - 1);
        chk("R4 recovering after done", ready, 1'b0);
        step(1);
        chk("R4 ready after late done", ready, 1'b1);

        step(2);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #800000;
        n_err++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule